// File: doc/BRIEF.md
# Tag-Snooping Reservation Station Pool

This block holds the operations waiting for one class of execution unit, such as floating-point adders. An operation arrives on the issue port with two sources. Each source is either a value that is already known or the tag of the pool entry that will produce it. The pool stores the operation in its lowest free entry and reports which tag it gave that entry. It raises a full flag when no entry is free.

On every clock the pool compares the result bus tag with each stored producer tag. Every field whose tag matches copies the broadcast data and clears its tag. An entry whose two tags are both zero is ready. The pool offers the lowest-numbered ready entry to the execution unit and passes the entry's operation code and tag along with it. It then waits for the result carrying that entry's tag to appear on the bus and releases the entry when it does.

Several pools can share one tag space, because the tag given to each entry starts at a base offset that is a parameter. Tag zero is reserved to mean "value present".

Top module: `rs_pool`

## Requirements
- R1: After reset every entry is free, `full_o` is 0 and `ex_valid_o` is 0.
- R2: An issue is accepted when `iss_valid_i` is 1 and `full_o` is 0. It goes into the lowest-numbered free entry, and in that same cycle `iss_tag_o` shows TAG_BASE + index + 1 for that entry (entry 0 gets TAG_BASE+1).
- R3: `full_o` is 1 exactly when all entries are busy. An issue attempted while the pool is full changes no entry.
- R4: A source whose issue tag is 0 takes the issued value at once. A source with a nonzero tag stores that tag and waits.
- R5: A broadcast with `bcast_valid_i` = 1 and a nonzero tag writes `bcast_data_i` into every waiting source field, in every entry, whose stored tag equals `bcast_tag_i`, and clears that tag. A broadcast with tag 0, or with `bcast_valid_i` = 0, captures nothing.
- R6: If a source is issued with the same nonzero tag that is being broadcast in that cycle, it takes the broadcast data and does not wait.
- R7: An entry is offered on `ex_valid_o` only while both of its stored tags are 0. The offer carries the entry's 3-bit operation code unchanged, both operand values, and the entry's tag.
- R8: When several entries are ready, the lowest-numbered one is offered. Exactly one entry is dispatched per cycle in which `ex_valid_o` and `ex_ready_i` are both 1. The offer stays up while `ex_ready_i` is 0, and a dispatched entry is not offered again.
- R9: An entry stays busy after it is dispatched and becomes free one cycle after a valid broadcast of its own tag. A broadcast of a tag that belongs to no entry of this pool frees nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | Issue request |
| iss_op_i | input | 3 | Operation code to store |
| iss_s1_tag_i | input | TAG_W | Producer tag of source 1, 0 = value given |
| iss_s1_val_i | input | DATA_W | Value of source 1 |
| iss_s2_tag_i | input | TAG_W | Producer tag of source 2, 0 = value given |
| iss_s2_val_i | input | DATA_W | Value of source 2 |
| iss_tag_o | output | TAG_W | Tag of the entry that takes the issue |
| full_o | output | 1 | All entries busy |
| bcast_valid_i | input | 1 | Result bus valid |
| bcast_tag_i | input | TAG_W | Tag of the producer on the result bus |
| bcast_data_i | input | DATA_W | Result value |
| ex_valid_o | output | 1 | A ready entry is offered |
| ex_ready_i | input | 1 | Execution unit accepts the offer |
| ex_op_o | output | 3 | Operation code of the offered entry |
| ex_a_o | output | DATA_W | Source 1 value |
| ex_b_o | output | DATA_W | Source 2 value |
| ex_tag_o | output | TAG_W | Tag of the offered entry |

## Verification
The bench builds the pool with three entries, 16-bit data, 4-bit tags and a base offset of 4, so the entry tags are 5, 6 and 7 and tags 1 and 2 stand for producers outside the pool. Three entries are few enough to fill the pool, issue into it while it is full, wake all entries with one broadcast, and free an entry in the middle so that lowest-free allocation can be seen. The bench sweeps all nine combinations of the two sources, each being ready at issue, waiting for a later broadcast, or bypassed by a broadcast in the same cycle. The nonzero base offset shows that tag allocation and release follow the offset, and that foreign tags wake operands but free nothing.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned OP_W = 3;
  typedef logic [OP_W-1:0] op_t;
endpackage

// File: rtl/rs_prio_pick.sv
module rs_prio_pick #(
  parameter int unsigned N     = 4,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !any_o) begin
        gnt_o[i] = 1'b1;
        idx_o    = IDX_W'(i);
        any_o    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_src_slot.sv
module rs_src_slot #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned TAG_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i,
  output logic [TAG_W-1:0]  q_o,
  output logic [DATA_W-1:0] v_o
);
  logic [TAG_W-1:0]  q_q;
  logic [DATA_W-1:0] v_q;
  logic hit_new, hit_old;

  assign hit_new = bc_valid_i && (tag_i != '0) && (bc_tag_i == tag_i);
  assign hit_old = bc_valid_i && (q_q != '0) && (bc_tag_i == q_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
      v_q <= '0;
    end else if (load_i) begin
      if (tag_i == '0) begin
        q_q <= '0;
        v_q <= val_i;
      end else if (hit_new) begin
        q_q <= '0;
        v_q <= bc_data_i;
      end else begin
        q_q <= tag_i;
      end
    end else if (hit_old) begin
      q_q <= '0;
      v_q <= bc_data_i;
    end
  end

  assign q_o = q_q;
  assign v_o = v_q;

  // R4
  ready_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && tag_i == '0 |=> q_o == '0 && v_o == $past(val_i));
  // R6
  bypass_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && bc_valid_i && tag_i != '0 && bc_tag_i == tag_i |=> q_o == '0 && v_o == $past(bc_data_i));
  // R5
  snoop_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && q_o != '0 && bc_valid_i && bc_tag_i == q_o |=> q_o == '0 && v_o == $past(bc_data_i));
  // R5
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && q_o != '0 && !(bc_valid_i && bc_tag_i == q_o) |=> $stable(q_o) && $stable(v_o));
endmodule

// File: rtl/rs_entry.sv
module rs_entry #(
  parameter int unsigned      DATA_W = 64,
  parameter int unsigned      TAG_W  = 4,
  parameter logic [TAG_W-1:0] MY_TAG = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  rs_pkg::op_t       op_i,
  input  logic [TAG_W-1:0]  s1_tag_i,
  input  logic [DATA_W-1:0] s1_val_i,
  input  logic [TAG_W-1:0]  s2_tag_i,
  input  logic [DATA_W-1:0] s2_val_i,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i,
  input  logic              disp_i,
  output logic              busy_o,
  output logic              ready_o,
  output rs_pkg::op_t       op_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o
);
  logic        busy_q, sent_q, own_done;
  rs_pkg::op_t op_q;
  logic [TAG_W-1:0] q1, q2;

  assign own_done = bc_valid_i && (bc_tag_i == MY_TAG);

  rs_src_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_s1 (
    .clk_i, .rst_ni, .load_i(alloc_i), .tag_i(s1_tag_i), .val_i(s1_val_i),
    .bc_valid_i, .bc_tag_i, .bc_data_i, .q_o(q1), .v_o(a_o)
  );
  rs_src_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_s2 (
    .clk_i, .rst_ni, .load_i(alloc_i), .tag_i(s2_tag_i), .val_i(s2_val_i),
    .bc_valid_i, .bc_tag_i, .bc_data_i, .q_o(q2), .v_o(b_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sent_q <= 1'b0;
      op_q   <= '0;
    end else if (alloc_i) begin
      busy_q <= 1'b1;
      sent_q <= 1'b0;
      op_q   <= op_i;
    end else if (busy_q && own_done) begin
      busy_q <= 1'b0;
      sent_q <= 1'b0;
    end else if (disp_i) begin
      sent_q <= 1'b1;
    end
  end

  assign busy_o  = busy_q;
  assign ready_o = busy_q && !sent_q && (q1 == '0) && (q2 == '0);
  assign op_o    = op_q;

  // R7
  disp_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_i |-> busy_q && q1 == '0 && q2 == '0);
  // R8
  no_redisp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sent_q |-> !disp_i);
  // R9
  free_on_own_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && own_done |=> !busy_q);
  // R3
  alloc_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !busy_q);
endmodule

// File: rtl/rs_pool.sv
module rs_pool #(
  parameter int unsigned NUM_ENT  = 3,
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned TAG_W    = 4,
  parameter int unsigned TAG_BASE = 0,
  localparam int unsigned IDX_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
  localparam int unsigned OP_W    = rs_pkg::OP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_valid_i,
  input  logic [OP_W-1:0]   iss_op_i,
  input  logic [TAG_W-1:0]  iss_s1_tag_i,
  input  logic [DATA_W-1:0] iss_s1_val_i,
  input  logic [TAG_W-1:0]  iss_s2_tag_i,
  input  logic [DATA_W-1:0] iss_s2_val_i,
  output logic [TAG_W-1:0]  iss_tag_o,
  output logic              full_o,
  input  logic              bcast_valid_i,
  input  logic [TAG_W-1:0]  bcast_tag_i,
  input  logic [DATA_W-1:0] bcast_data_i,
  output logic              ex_valid_o,
  input  logic              ex_ready_i,
  output logic [OP_W-1:0]   ex_op_o,
  output logic [DATA_W-1:0] ex_a_o,
  output logic [DATA_W-1:0] ex_b_o,
  output logic [TAG_W-1:0]  ex_tag_o
);
  localparam logic [TAG_W-1:0] FIRST_TAG = TAG_W'(TAG_BASE + 1);

  logic [NUM_ENT-1:0] busy_vec, ready_vec, free_gnt, disp_gnt, alloc_vec, disp_vec;
  logic [IDX_W-1:0]   free_idx, disp_idx;
  logic               any_free, any_ready;
  rs_pkg::op_t        op_arr [NUM_ENT];
  logic [DATA_W-1:0]  a_arr  [NUM_ENT];
  logic [DATA_W-1:0]  b_arr  [NUM_ENT];

  rs_prio_pick #(.N(NUM_ENT)) u_alloc_pick (
    .req_i(~busy_vec), .gnt_o(free_gnt), .idx_o(free_idx), .any_o(any_free)
  );
  rs_prio_pick #(.N(NUM_ENT)) u_disp_pick (
    .req_i(ready_vec), .gnt_o(disp_gnt), .idx_o(disp_idx), .any_o(any_ready)
  );

  assign alloc_vec = free_gnt & {NUM_ENT{iss_valid_i}};
  assign disp_vec  = disp_gnt & {NUM_ENT{ex_ready_i}};

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    rs_entry #(
      .DATA_W(DATA_W), .TAG_W(TAG_W), .MY_TAG(TAG_W'(TAG_BASE + g + 1))
    ) u_ent (
      .clk_i, .rst_ni,
      .alloc_i(alloc_vec[g]), .op_i(iss_op_i),
      .s1_tag_i(iss_s1_tag_i), .s1_val_i(iss_s1_val_i),
      .s2_tag_i(iss_s2_tag_i), .s2_val_i(iss_s2_val_i),
      .bc_valid_i(bcast_valid_i), .bc_tag_i(bcast_tag_i), .bc_data_i(bcast_data_i),
      .disp_i(disp_vec[g]),
      .busy_o(busy_vec[g]), .ready_o(ready_vec[g]),
      .op_o(op_arr[g]), .a_o(a_arr[g]), .b_o(b_arr[g])
    );
  end

  assign full_o     = !any_free;
  assign iss_tag_o  = FIRST_TAG + TAG_W'(free_idx);
  assign ex_valid_o = any_ready;
  assign ex_op_o    = op_arr[disp_idx];
  assign ex_a_o     = a_arr[disp_idx];
  assign ex_b_o     = b_arr[disp_idx];
  assign ex_tag_o   = FIRST_TAG + TAG_W'(disp_idx);

  // R3
  full_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && iss_valid_i |=> (busy_vec & ~$past(busy_vec)) == '0);
  // R8
  offer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_valid_o && !ex_ready_i && !(bcast_valid_i && bcast_tag_i == ex_tag_o) |=> ex_valid_o);
endmodule

// File: tb/rs_pool_test.sv
module rs_pool_test;
  localparam int unsigned N = 3, DW = 16, TW = 4, TB = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic iss_valid_i = 0, bcast_valid_i = 0, ex_ready_i = 0;
  logic [2:0] iss_op_i = '0;
  logic [TW-1:0] iss_s1_tag_i = '0, iss_s2_tag_i = '0, bcast_tag_i = '0;
  logic [DW-1:0] iss_s1_val_i = '0, iss_s2_val_i = '0, bcast_data_i = '0;
  logic [TW-1:0] iss_tag_o, ex_tag_o;
  logic full_o, ex_valid_o;
  logic [2:0] ex_op_o;
  logic [DW-1:0] ex_a_o, ex_b_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  rs_pool #(.NUM_ENT(N), .DATA_W(DW), .TAG_W(TW), .TAG_BASE(TB)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic issue(input logic [2:0] op, input logic [TW-1:0] t1, input logic [DW-1:0] v1,
                       input logic [TW-1:0] t2, input logic [DW-1:0] v2);
    iss_valid_i = 1; iss_op_i = op;
    iss_s1_tag_i = t1; iss_s1_val_i = v1; iss_s2_tag_i = t2; iss_s2_val_i = v2;
  endtask

  task automatic bc(input logic v, input logic [TW-1:0] t, input logic [DW-1:0] d);
    bcast_valid_i = v; bcast_tag_i = t; bcast_data_i = d;
  endtask

  initial begin
    repeat (4000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    #1;
    chk("R1 full", full_o, 0);
    chk("R1 ex_valid", ex_valid_o, 0);
    cyc(); rst_ni = 1;

    // sweep: per source 0=ready at issue, 1=waits for tag 1, 2=bypass on tag 2
    for (int c = 0; c < 9; c++) begin
      int m1 = c / 3, m2 = c % 3;
      logic [DW-1:0] va = 16'h3000 + DW'(c), vb = 16'h4000 + DW'(c);
      logic [DW-1:0] d1 = 16'h5000 + DW'(c), d2 = 16'h2000 + DW'(c);
      logic [DW-1:0] ea = (m1 == 0) ? va : (m1 == 1) ? d1 : d2;
      logic [DW-1:0] eb = (m2 == 0) ? vb : (m2 == 1) ? d1 : d2;
      bit wt = (m1 == 1) || (m2 == 1);
      cyc();
      issue(3'(c), TW'(m1), (m1 == 0) ? va : 16'hdead, TW'(m2), (m2 == 0) ? vb : 16'hbeef);
      bc(m1 == 2 || m2 == 2, 4'd2, d2);
      #1;
      chk("R2 iss_tag", iss_tag_o, TB + 1);
      chk("R3 full", full_o, 0);
      cyc(); iss_valid_i = 0; bc(0, 0, 0); #1;
      chk("R7 ready after issue", ex_valid_o, !wt);
      if (wt) begin
        cyc(); bc(1, 4'd1, d1); #1;
        chk("R7 still waiting", ex_valid_o, 0);
        cyc(); bc(0, 0, 0); #1;
        chk("R5 woken", ex_valid_o, 1);
      end
      chk("R7 op", ex_op_o, c % 8);
      chk(m1 == 0 ? "R4 a" : m1 == 1 ? "R5 a" : "R6 a", ex_a_o, ea);
      chk(m2 == 0 ? "R4 b" : m2 == 1 ? "R5 b" : "R6 b", ex_b_o, eb);
      chk("R7 tag", ex_tag_o, TB + 1);
      ex_ready_i = 1;
      cyc(); ex_ready_i = 0; #1;
      chk("R8 not reoffered", ex_valid_o, 0);
      cyc(); bc(1, TB + 1, 16'h7777);
      cyc(); bc(0, 0, 0);
    end

    // fill the pool, then exercise full, wakeup, order and release
    cyc(); issue(3'd1, 4'd1, 16'h0, 4'd0, 16'h0a00); #1;
    chk("R2 tag e0", iss_tag_o, TB + 1);
    cyc(); issue(3'd2, 4'd0, 16'h0b01, 4'd1, 16'h0); #1;
    chk("R2 tag e1", iss_tag_o, TB + 2);
    cyc(); issue(3'd3, 4'd1, 16'h0, 4'd1, 16'h0); #1;
    chk("R2 tag e2", iss_tag_o, TB + 3);
    cyc(); iss_valid_i = 0; #1;
    chk("R3 full set", full_o, 1);
    chk("R7 none ready", ex_valid_o, 0);
    cyc(); issue(3'd7, 4'd0, 16'hffff, 4'd0, 16'hffff); bc(1, 4'd0, 16'hbad0); #1;
    chk("R3 full on issue", full_o, 1);
    cyc(); iss_valid_i = 0; bc(0, 4'd1, 16'hbad1); #1;
    chk("R3 ignored issue no offer", ex_valid_o, 0);
    cyc(); bc(1, 4'd1, 16'h0c0c); #1;
    chk("R5 no capture w/o valid", ex_valid_o, 0);
    cyc(); bc(0, 0, 0); #1;
    chk("R8 lowest tag", ex_tag_o, TB + 1);
    chk("R5 e0 a", ex_a_o, 16'h0c0c);
    chk("R3 e0 b kept", ex_b_o, 16'h0a00);
    chk("R7 e0 op", ex_op_o, 1);
    cyc(); #1;
    chk("R8 held", ex_tag_o, TB + 1);
    chk("R8 held valid", ex_valid_o, 1);
    ex_ready_i = 1;
    cyc(); #1;
    chk("R8 next tag", ex_tag_o, TB + 2);
    chk("R5 e1 b", ex_b_o, 16'h0c0c);
    chk("R4 e1 a", ex_a_o, 16'h0b01);
    cyc(); #1;
    chk("R8 third tag", ex_tag_o, TB + 3);
    chk("R5 e2 a", ex_a_o, 16'h0c0c);
    chk("R5 e2 b", ex_b_o, 16'h0c0c);
    chk("R7 e2 op", ex_op_o, 3);
    cyc(); ex_ready_i = 0; #1;
    chk("R8 all sent", ex_valid_o, 0);
    chk("R9 busy after dispatch", full_o, 1);
    cyc(); bc(1, 4'd2, 16'h1111); #1;
    chk("R9 foreign tag", full_o, 1);
    cyc(); bc(1, TB + 2, 16'h2222); #1;
    chk("R9 foreign no free", full_o, 1);
    cyc(); bc(0, 0, 0); #1;
    chk("R9 middle freed", full_o, 0);
    issue(3'd4, 4'd0, 16'h0101, 4'd0, 16'h0202); #1;
    chk("R2 lowest free", iss_tag_o, TB + 2);
    cyc(); iss_valid_i = 0; #1;
    chk("R7 reissued tag", ex_tag_o, TB + 2);
    chk("R4 reissued a", ex_a_o, 16'h0101);
    chk("R7 reissued op", ex_op_o, 4);
    ex_ready_i = 1;
    cyc(); ex_ready_i = 0; bc(1, TB + 1, 0);
    cyc(); bc(1, TB + 3, 0);
    cyc(); bc(1, TB + 2, 0);
    cyc(); bc(0, 0, 0); #1;
    chk("R9 all free", full_o, 0);
    chk("R9 no offer", ex_valid_o, 0);
    chk("R2 first again", iss_tag_o, TB + 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule